// File: doc/BRIEF.md
# Periodic Rate Generator and Interrupt Status

This block turns a 32.768 kHz time-base clock into a programmable periodic tick and an optional square wave. It also keeps the interrupt status byte that gathers three event sources: the periodic tick, an alarm match strobe and an update-complete strobe. The alarm and update strobes come from the time-of-day core, which is outside this block. Each source has its own enable. When a flag and its enable are both set, the block raises the interrupt line and sets the summary bit of the status byte.

Software reads the status byte by pulsing `rd_stat` for one clock. During that cycle the byte shows the current flags, and the edge that ends the cycle clears them. The divider runs only while the time-base select field holds the run code. Any other code keeps the divider cleared, and no periodic tick or square-wave edge can occur while it is held.

Top module: `rtc_periodic_irq`

## Requirements
- R1: The divider counts one step per clock only while `dv_sel` equals 3'b010. Any other value holds it cleared: no periodic tick occurs and `sqw` stays low. After the run code is applied, the first tick again falls a full period later.
- R2: Rate code 1 gives a period of 128 clocks (256 Hz). Code 2 gives 256 clocks (128 Hz). A code c from 3 to 15 gives 2^(c-1) clocks, which is 32768 >> (c-1) Hz. The periodic flag is set at the edge that completes exactly one period after the divider is released.
- R3: Rate code 0 produces no periodic tick and keeps `sqw` low.
- R4: When `sqwe` is 1 and the rate code is not 0, `sqw` is low for the first half of each period and high for the second half, counted from divider release. When `sqwe` is 0, `sqw` is low.
- R5: The status byte is {summary, periodic, alarm, update, 4'b0000}, from bit 7 down to bit 0. Bits 3..0 always read 0.
- R6: A one-cycle `alarm_evt` or `update_evt` strobe sets bit 5 or bit 4 at the next edge. The bit then holds until a read. A flag is set whether or not its enable is on.
- R7: `irq` and status bit 7 are 1 exactly when (periodic & `pie`) | (alarm & `aie`) | (update & `uie`). Changing an enable takes effect in the same cycle.
- R8: During a cycle with `rd_stat` high, the status byte shows the flags as they are. The edge that ends that cycle clears all flags, and `irq` drops.
- R9: An event arriving in the same cycle as a read survives the read: its flag is 1 after the clearing edge.
- R10: While reset is asserted, the status byte is 0, `irq` is 0 and `sqw` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz time-base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dv_sel | input | 3 | Time-base select; 3'b010 runs the divider |
| rate_sel | input | 4 | Periodic rate code |
| pie | input | 1 | Periodic interrupt enable |
| aie | input | 1 | Alarm interrupt enable |
| uie | input | 1 | Update-complete interrupt enable |
| sqwe | input | 1 | Square-wave output enable |
| alarm_evt | input | 1 | One-cycle alarm match strobe |
| update_evt | input | 1 | One-cycle update-complete strobe |
| rd_stat | input | 1 | Status read strobe; clears flags at cycle end |
| irq | output | 1 | Interrupt request, active high |
| sqw | output | 1 | Square-wave output |
| stat | output | 8 | Interrupt status byte |

## Verification
If the divider count is wrong, the error shows at `sqw` within half a period of release. The periodic flag then comes one or more edges early or late, so the bench samples both at the exact edge numbers derived from the rate code. A flag register that holds the wrong value shows up on `stat` and `irq` in the cycle right after the strobe or read that should have changed it. A lost coincident event shows up as a zero alarm bit immediately after the clearing edge.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  localparam int unsigned DIV_W   = 15;
  localparam int unsigned LOG_W   = 5;
  localparam logic [2:0]  DV_RUN  = 3'b010;

  // log2 of the periodic period in time-base clocks; 0 means no tick
  function automatic logic [LOG_W-1:0] rate_log2(input logic [3:0] code);
    logic [LOG_W-1:0] r;
    case (code)
      4'd0:    r = '0;
      4'd1:    r = LOG_W'(7);
      4'd2:    r = LOG_W'(8);
      default: r = LOG_W'(code) - LOG_W'(1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rpg_divider.sv
module rpg_divider #(
  parameter int unsigned DIV_W = rpg_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [DIV_W-1:0] div
);
  always_ff @(posedge clk) begin
    if (!rst_n || !run) div <= '0;
    else                div <= div + 1'b1;
  end
endmodule

// File: rtl/rpg_rate.sv
module rpg_rate #(
  parameter int unsigned DIV_W = rpg_pkg::DIV_W,
  parameter int unsigned LOG_W = rpg_pkg::LOG_W
) (
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  input  logic [3:0]       rate_sel,
  input  logic             sqwe,
  output logic             tick,
  output logic             sqw
);
  logic [DIV_W:1]   wrap;
  logic [LOG_W-1:0] k;

  for (genvar g = 1; g <= DIV_W; g++) begin : g_wrap
    assign wrap[g] = &div[g-1:0];
  end

  always_comb begin
    k    = rpg_pkg::rate_log2(rate_sel);
    tick = 1'b0;
    sqw  = 1'b0;
    if (run && k != '0) begin
      tick = wrap[k];
      sqw  = sqwe & div[k - LOG_W'(1)];
    end
  end
endmodule

// File: rtl/rpg_flags.sv
module rpg_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic alarm_evt,
  input  logic update_evt,
  input  logic rd_stat,
  input  logic pie,
  input  logic aie,
  input  logic uie,
  output logic pf,
  output logic af,
  output logic uf,
  output logic irqf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf <= 1'b0;
      af <= 1'b0;
      uf <= 1'b0;
    end else begin
      pf <= (pf & ~rd_stat) | tick;
      af <= (af & ~rd_stat) | alarm_evt;
      uf <= (uf & ~rd_stat) | update_evt;
    end
  end

  assign irqf = (pf & pie) | (af & aie) | (uf & uie);
endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq #(
  parameter int unsigned DIV_W  = rpg_pkg::DIV_W,
  parameter logic [2:0]  DV_RUN = rpg_pkg::DV_RUN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] dv_sel,
  input  logic [3:0] rate_sel,
  input  logic       pie,
  input  logic       aie,
  input  logic       uie,
  input  logic       sqwe,
  input  logic       alarm_evt,
  input  logic       update_evt,
  input  logic       rd_stat,
  output logic       irq,
  output logic       sqw,
  output logic [7:0] stat
);
  logic             div_run;
  logic [DIV_W-1:0] div;
  logic             per_tick;
  logic             pf, af, uf, irqf;

  assign div_run = (dv_sel == DV_RUN);

  rpg_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(div_run), .div(div)
  );

  rpg_rate #(.DIV_W(DIV_W)) u_rate (
    .div(div), .run(div_run), .rate_sel(rate_sel), .sqwe(sqwe),
    .tick(per_tick), .sqw(sqw)
  );

  rpg_flags u_flags (
    .clk(clk), .rst_n(rst_n), .tick(per_tick), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .rd_stat(rd_stat), .pie(pie), .aie(aie),
    .uie(uie), .pf(pf), .af(af), .uf(uf), .irqf(irqf)
  );

  assign irq  = irqf;
  assign stat = {irqf, pf, af, uf, 4'b0000};
endmodule

// File: rtl/rpg_checker.sv
module rpg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       tick,
  input logic [3:0] rate_sel,
  input logic       sqwe,
  input logic       pie,
  input logic       aie,
  input logic       uie,
  input logic       alarm_evt,
  input logic       update_evt,
  input logic       rd_stat,
  input logic       irq,
  input logic       sqw,
  input logic [7:0] stat
);
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n) !run |-> !tick && !sqw); // R1
  AST_TICK_SETS_PF: assert property (@(posedge clk) disable iff (!rst_n) tick |=> stat[6]); // R2
  AST_RATE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n) rate_sel == 4'd0 |-> !tick && !sqw); // R3
  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n) !sqwe |-> !sqw); // R4
  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n) alarm_evt |=> stat[5]); // R6
  AST_UPDATE_SETS: assert property (@(posedge clk) disable iff (!rst_n) update_evt |=> stat[4]); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) irq |-> (stat[6] && pie) || (stat[5] && aie) || (stat[4] && uie)); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rd_stat && !tick && !alarm_evt && !update_evt |=> stat == 8'h00 && !irq); // R8
endmodule

bind rtc_periodic_irq rpg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(div_run), .tick(per_tick),
  .rate_sel(rate_sel), .sqwe(sqwe), .pie(pie), .aie(aie), .uie(uie),
  .alarm_evt(alarm_evt), .update_evt(update_evt), .rd_stat(rd_stat),
  .irq(irq), .sqw(sqw), .stat(stat)
);

// File: tb/rtc_periodic_irq_bench.sv
module rtc_periodic_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] dv_sel = 3'b000;
  logic [3:0] rate_sel = 4'd0;
  logic       pie = 0, aie = 0, uie = 0, sqwe = 0;
  logic       alarm_evt = 0, update_evt = 0, rd_stat = 0;
  logic       irq, sqw;
  logic [7:0] stat;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_periodic_irq u_rtc_periodic_irq (
    .clk(clk), .rst_n(rst_n), .dv_sel(dv_sel), .rate_sel(rate_sel),
    .pie(pie), .aie(aie), .uie(uie), .sqwe(sqwe), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .rd_stat(rd_stat), .irq(irq), .sqw(sqw), .stat(stat)
  );

  // code, expected frequency in Hz
  localparam int NV = 7;
  localparam int VEC [NV][2] = '{
    '{1, 256}, '{2, 128}, '{3, 8192}, '{4, 4096}, '{6, 1024}, '{9, 128}, '{15, 2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd_stat = 1'b1;
    wait_n(1);
    rd_stat = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    chk("R10 stat", stat, 8'h00);
    chk("R10 irq", irq, 0);
    chk("R10 sqw", sqw, 0);
    rst_n = 1'b1;
    wait_n(1);

    // table walk: period and square-wave phase for each rate code
    for (int i = 0; i < NV; i++) begin
      int per, half;
      per  = 32768 / VEC[i][1];
      half = per / 2;
      dv_sel = 3'b000; rate_sel = 4'(VEC[i][0]); sqwe = 1'b1; pie = 1'b0;
      do_read();
      dv_sel = 3'b010;
      wait_n(half - 1);
      chk("R4 sqw low first half", sqw, 0);
      chk("R2 no flag early", stat[6], 0);
      wait_n(1);
      chk("R4 sqw high second half", sqw, 1);
      wait_n(per - half - 1);
      chk("R2 no flag before period", stat[6], 0);
      wait_n(1);
      chk("R2 flag at period", stat[6], 1);
      chk("R4 sqw low after wrap", sqw, 0);
    end

    // R3: code 0 silent
    dv_sel = 3'b000; rate_sel = 4'd0; do_read();
    dv_sel = 3'b010;
    wait_n(1000);
    chk("R3 no flag", stat[6], 0);
    chk("R3 sqw low", sqw, 0);

    // R1: non-run select holds divider
    rate_sel = 4'd3; dv_sel = 3'b011; do_read();
    wait_n(50);
    chk("R1 held no flag", stat[6], 0);
    chk("R1 held sqw", sqw, 0);
    dv_sel = 3'b010;
    wait_n(3);
    chk("R1 resume not early", stat[6], 0);
    wait_n(1);
    chk("R1 resume flag", stat[6], 1);

    // R7/R5: enable gating
    dv_sel = 3'b000;
    wait_n(1);
    chk("R7 flag without enable", stat, 8'h40);
    chk("R7 irq off", irq, 0);
    pie = 1'b1;
    #1;
    chk("R7 irq on", irq, 1);
    chk("R5 layout", stat, 8'hC0);

    // R8: read shows then clears
    rd_stat = 1'b1;
    #1;
    chk("R8 read shows", stat, 8'hC0);
    wait_n(1);
    rd_stat = 1'b0;
    chk("R8 cleared", stat, 8'h00);
    chk("R8 irq dropped", irq, 0);

    // R6: alarm and update strobes
    alarm_evt = 1'b1; wait_n(1); alarm_evt = 1'b0;
    chk("R6 alarm flag", stat, 8'h20);
    chk("R6 irq off", irq, 0);
    wait_n(5);
    chk("R6 alarm held", stat, 8'h20);
    aie = 1'b1;
    #1;
    chk("R7 alarm irq", irq, 1);
    update_evt = 1'b1; wait_n(1); update_evt = 1'b0;
    chk("R6 update flag", stat, 8'hB0);
    uie = 1'b1; aie = 1'b0;
    #1;
    chk("R7 update irq", stat, 8'hB0);
    uie = 1'b0;
    #1;
    chk("R7 all disabled", irq, 0);

    // R9: event coinciding with read
    rd_stat = 1'b1; alarm_evt = 1'b1;
    wait_n(1);
    rd_stat = 1'b0; alarm_evt = 1'b0;
    chk("R9 event survives", stat, 8'h20);

    // R4: sqwe off
    do_read();
    rate_sel = 4'd3; sqwe = 1'b0; dv_sel = 3'b010;
    for (int j = 0; j < 8; j++) begin
      wait_n(1);
      chk("R4 sqw disabled", sqw, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule